// File: doc/BRIEF.md
# Dual-Channel Narrow Link Framer

This block serialises one sample period of two complex baseband channels onto a narrow parallel link. Each accepted sample brings four signed words: in-phase and quadrature for channel A, and the same for channel B. The block adds a running frame count and sends everything as a fixed frame of link beats. A one-beat start marker runs beside the data bus. A receiver on the far side uses the marker and the count to line up frames that come from several boards. For that reason every board must produce frames at exactly the same rate.

The beat schedule is fixed. The sample words go first, in the order A-I, A-Q, B-I, B-Q, and the frame count follows them. The frame is sent most significant bit first. When no frame is in flight, the bus carries zeros and the marker stays low. A sample that arrives while a frame is still being sent is discarded, and a sticky error flag records the event.

Top module: `link_framer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `link_data` is 0, `link_sof` is 0 and `overrun` is 0.
- R2: After reset and before the first `in_valid`, every beat has `link_data` = 0 and `link_sof` = 0.
- R3: A sample accepted at a clock edge starts a frame of BEATS = 8 beats on the following cycle. `link_sof` is high on the first beat only.
- R4: The 40-bit frame word is {a_i, a_q, b_i, b_q, count[11:0]}, where each sample field is 7 bits. Beat n (n = 0..7) carries frame bits [39-5n : 35-5n] on `link_data[4:0]`.
- R5: The count field of the first frame after reset is 0. It rises by one for each accepted sample and wraps from 4095 to 0.
- R6: A sample presented at the edge that ends beat 7 is accepted, so the next frame follows with no gap. Samples every 8 cycles therefore give an unbroken stream.
- R7: A sample presented while beat 0..6 is on the bus is discarded. The frame in flight is unchanged, the count does not advance, and `overrun` goes high and stays high until reset.
- R8: When beat 7 ends without a new sample, the bus returns to zeros with `link_sof` low until the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; one beat per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new sample set is presented this cycle |
| a_i | input | 7 | Channel A in-phase sample |
| a_q | input | 7 | Channel A quadrature sample |
| b_i | input | 7 | Channel B in-phase sample |
| b_q | input | 7 | Channel B quadrature sample |
| link_data | output | 5 | Current beat of the frame |
| link_sof | output | 1 | High on the first beat of each frame |
| overrun | output | 1 | Sticky flag: a sample was discarded |

## Verification
The bench builds the block with its default parameters: 7-bit samples, a 5-bit bus and 8 beats. These values leave a 12-bit count field, so the 4095-to-0 wrap is reached after 4096 back-to-back frames, about 33,000 cycles. The narrow bus makes every field straddle beat boundaries, which exposes any ordering or shift error. The bench also covers samples placed on the last beat and on an earlier beat, which are the accept and discard boundaries.

// File: rtl/link_framer_pkg.sv
package link_framer_pkg;

    typedef enum logic {
        LF_IDLE = 1'b0,
        LF_SEND = 1'b1
    } lf_state_e;

    // Width of the count field left over once the sample words are placed.
    function automatic int lf_count_width(input int frame_w, input int data_w);
        return frame_w - data_w;
    endfunction

endpackage

// File: rtl/lf_beat_ctrl.sv
module lf_beat_ctrl
    import link_framer_pkg::*;
#(
    parameter int BEATS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic load,
    output logic sending,
    output logic first_beat,
    output logic overrun
);
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    lf_state_e         state;
    logic [BEAT_W-1:0] beat;
    logic              last_beat;
    logic              can_accept;

    assign last_beat  = (state == LF_SEND) && (beat == LAST_BEAT);
    assign can_accept = (state == LF_IDLE) || last_beat;
    assign load       = in_valid && can_accept;
    assign sending    = (state == LF_SEND);
    assign first_beat = (state == LF_SEND) && (beat == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LF_IDLE;
            beat    <= '0;
            overrun <= 1'b0;
        end else begin
            if (in_valid && !can_accept)
                overrun <= 1'b1;
            if (load) begin
                state <= LF_SEND;
                beat  <= '0;
            end else if (last_beat) begin
                state <= LF_IDLE;
                beat  <= '0;
            end else if (state == LF_SEND) begin
                beat <= beat + 1'b1;
            end
        end
    end

    // R7: a sample arriving mid-frame raises the flag
    p_drop_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !can_accept) |=> overrun);
    // R7: flag holds until reset
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
    // R3: an accepted sample opens a frame on the next beat
    p_load_opens_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> first_beat);
    // R8: frame end without a sample leads to idle
    p_end_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (last_beat && !in_valid) |=> !sending);
endmodule

// File: rtl/lf_sample_count.sv
module lf_sample_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= count + 1'b1;
    end

    // R5: one step per accepted sample, wrapping modulo 2**CNT_W
    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> count == CNT_W'($past(count) + 1'b1));
    // R7: no accepted sample, no advance
    p_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(count));
endmodule

// File: rtl/lf_beat_shifter.sv
module lf_beat_shifter #(
    parameter int FRAME_W = 40,
    parameter int LINK_W  = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               sending,
    input  logic [FRAME_W-1:0] frame_in,
    output logic [LINK_W-1:0]  beat_data
);
    logic [FRAME_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)
            sreg <= '0;
        else if (load)
            sreg <= frame_in;
        else if (sending)
            sreg <= sreg << LINK_W;
    end

    assign beat_data = sreg[FRAME_W-1 -: LINK_W];

    // R4: first beat is the top slice of the loaded frame
    p_load_top_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> beat_data == $past(frame_in[FRAME_W-1 -: LINK_W]));
    // R4: each later beat is the next lower slice
    p_next_slice_r4: assert property (@(posedge clk) disable iff (rst)
        (sending && !load) |=> beat_data == $past(sreg[FRAME_W-1-LINK_W -: LINK_W]));
endmodule

// File: rtl/link_framer.sv
module link_framer
    import link_framer_pkg::*;
#(
    parameter int SAMPLE_W = 7,
    parameter int LINK_W   = 5,
    parameter int BEATS    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] a_i,
    input  logic [SAMPLE_W-1:0] a_q,
    input  logic [SAMPLE_W-1:0] b_i,
    input  logic [SAMPLE_W-1:0] b_q,
    output logic [LINK_W-1:0]   link_data,
    output logic                link_sof,
    output logic                overrun
);
    localparam int WORDS   = 4;
    localparam int DATA_W  = WORDS * SAMPLE_W;
    localparam int FRAME_W = BEATS * LINK_W;
    localparam int CNT_W   = lf_count_width(FRAME_W, DATA_W);

    logic                load;
    logic                sending;
    logic                first_beat;
    logic [CNT_W-1:0]    count;
    logic [FRAME_W-1:0]  frame_word;
    logic [LINK_W-1:0]   beat_data;
    logic [SAMPLE_W-1:0] words [WORDS];

    assign words[0] = a_i;
    assign words[1] = a_q;
    assign words[2] = b_i;
    assign words[3] = b_q;

    // Sample words fill the frame from the top, the count sits below them.
    for (genvar w = 0; w < WORDS; w++) begin : g_place
        assign frame_word[FRAME_W-1-w*SAMPLE_W -: SAMPLE_W] = words[w];
    end
    assign frame_word[CNT_W-1:0] = count;

    lf_beat_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .load       (load),
        .sending    (sending),
        .first_beat (first_beat),
        .overrun    (overrun)
    );

    lf_sample_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .count (count)
    );

    lf_beat_shifter #(.FRAME_W(FRAME_W), .LINK_W(LINK_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .sending   (sending),
        .frame_in  (frame_word),
        .beat_data (beat_data)
    );

    assign link_data = sending ? beat_data : '0;
    assign link_sof  = first_beat;

    // R3: a marker is only ever preceded by a presented sample
    p_sof_after_valid_r3: assert property (@(posedge clk) disable iff (rst)
        link_sof |-> $past(in_valid));
    // R3: marker never on two adjacent beats
    p_sof_single_r3: assert property (@(posedge clk) disable iff (rst)
        link_sof |=> !link_sof);
endmodule

// File: tb/link_framer_tb_top.sv
module link_framer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [6:0] a_i = '0, a_q = '0, b_i = '0, b_q = '0;
    logic [4:0] link_data;
    logic       link_sof;
    logic       overrun;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [5:0] beat_q[$];
    logic [4:0] exp_data = '0;
    logic       exp_sof  = 1'b0;
    logic       exp_ovr  = 1'b0;
    int         exp_cnt  = 0;

    always #5 clk = ~clk;

    link_framer dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_i(a_i), .a_q(a_q), .b_i(b_i), .b_q(b_q),
        .link_data(link_data), .link_sof(link_sof), .overrun(overrun)
    );

    always @(posedge clk) begin
        if (rst) begin
            beat_q.delete();
            exp_data = '0; exp_sof = 1'b0; exp_ovr = 1'b0; exp_cnt = 0;
        end else if (in_valid && beat_q.size() == 0) begin
            logic [39:0] fr;
            fr = {a_i, a_q, b_i, b_q, 12'(exp_cnt)};
            exp_cnt = (exp_cnt + 1) % 4096;
            for (int n = 0; n < 8; n++)
                beat_q.push_back({(n == 0), fr[39-5*n -: 5]});
            {exp_sof, exp_data} = beat_q.pop_front();
        end else begin
            if (in_valid) exp_ovr = 1'b1;
            if (beat_q.size() > 0) {exp_sof, exp_data} = beat_q.pop_front();
            else begin exp_sof = 1'b0; exp_data = '0; end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_cmp++;
            if (link_data !== exp_data || link_sof !== exp_sof || overrun !== exp_ovr) begin
                n_bad++;
                $display("FAIL %s cyc %0d: data/sof/ovr actual %h/%b/%b expected %h/%b/%b",
                         cur_req, cyc, link_data, link_sof, overrun, exp_data, exp_sof, exp_ovr);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic put(input logic [6:0] ai, aq, bi, bq);
        @(negedge clk);
        a_i = ai; a_q = aq; b_i = bi; b_q = bq; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {4'b0, link_data, link_sof, overrun} , 7'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {4'b0, link_data, link_sof, overrun}, 7'd0);
        // R2: idle zeros before any sample
        cur_req = "R2";
        idle(6);
        // R3/R4: one known frame, then R8 idle
        cur_req = "R4";
        put(7'h55, 7'h2A, 7'h7F, 7'h01);
        idle(6);
        cur_req = "R8";
        idle(10);
        check("R8", {5'b0, link_sof, overrun}, 7'd0);
        // R6: back-to-back frames every 8 cycles
        cur_req = "R6";
        for (int f = 0; f < 6; f++) begin
            put(7'(f * 9), 7'(f + 3), 7'(~f), 7'(f * 17));
            idle(6);
        end
        idle(12);
        cur_req = "R3";
        put(7'h11, 7'h22, 7'h33, 7'h44);
        idle(12);
        // R7: sample during beat 2 dropped
        cur_req = "R7";
        put(7'h0F, 7'h70, 7'h3C, 7'h43);
        idle(1);
        put(7'h7E, 7'h7E, 7'h7E, 7'h7E);
        idle(12);
        check("R7", {6'b0, overrun}, 7'd1);
        // R5: long run through the count wrap
        cur_req = "R5";
        for (int f = 0; f < 4100; f++) begin
            put(7'($urandom), 7'($urandom), 7'($urandom), 7'($urandom));
            idle(6);
        end
        idle(12);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule